// File: doc/BRIEF.md
# GPIO Bank with Edge Detection

A register-mapped bank of up to 32 general-purpose pins behind a simple 32-bit read/write register bus. Software drives an output latch through two write-only ports, one that sets bits and one that clears them. It chooses per pin whether the pad driver is enabled, and it reads back the synchronized pin levels. Each pin input passes through a two-flop synchronizer. A third flop keeps the previous synchronized sample, and comparing the two finds rising and falling transitions.

Separate rising and falling enable registers gate those transitions per pin into a sticky status register. Software clears status bits by writing ones to them. The single bank interrupt is the OR of all status bits. The parameter `NUM_PINS` sets how many low-order pins exist. The remaining bit positions read as zero, drive nothing and never raise status.

Register access is decoded into an enumerated register selector (none, level, direction, set, clear, rise-enable, fall-enable, status). A write takes effect on the clock edge where `bus_en` and `bus_we` are high. Reads are combinational while `bus_en` is high.

Top module: `gpio_edge_bank`

## Requirements
- R1: After reset every register reads zero, `pad_out` and `pad_oe` are zero and `irq` is low.
- R2: Writing to the set port (offset 0x18) forces each latch bit written as 1 high and leaves the others unchanged. `pad_out` shows the new latch on the cycle after the write. The set port reads as zero.
- R3: Writing to the clear port (offset 0x24) forces each latch bit written as 1 low and leaves the others unchanged. The clear port reads as zero.
- R4: The direction register (offset 0x0C) reads back as written and drives `pad_oe` directly: a bit of 1 enables the driver (output) and 0 makes the pin an input. Direction does not alter the latch.
- R5: The level register (offset 0x00) returns `pad_in` delayed by the two synchronizer flops. A change driven before a rising edge is visible after the second rising edge and not after the first.
- R6: With a pin's rising enable set (offset 0x30), a low-to-high input change sets its status bit, which is visible after the third rising edge following the change.
- R7: With a pin's falling enable set (offset 0x3C), a high-to-low input change sets its status bit with the same latency as R6. Both enables may be set together.
- R8: A transition on a pin whose matching enable is clear leaves its status bit at zero.
- R9: The status register (offset 0x48) is sticky. Writing 1 to a bit clears it, and bits written as 0 keep their value. Writing all ones clears every bit.
- R10: If a new enabled transition on a pin lands in the same cycle as a write-one-to-clear of its status bit, the bit stays set.
- R11: `irq` is high exactly when at least one status bit is set.
- R12: Bit positions at or above `NUM_PINS` read as zero in every register, drive zero on `pad_out` and `pad_oe`, and never set status whatever `pad_in` does there.
- R13: Reads at offsets other than the seven listed return zero, and writes there change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when `bus_en` is low |
| pad_in | input | 32 | Pin input levels |
| pad_out | output | 32 | Output latch to the pads |
| pad_oe | output | 32 | Pad driver enable |
| irq | output | 1 | Bank interrupt, OR of status bits |

## Verification
The bench sweeps all 256 set and clear patterns and all direction values of an 8-pin instance. It also walks every pin through both transition directions under all four enable combinations, reading status one cycle before and at the expected cycle. A design that swapped the two enables, read status a cycle early, or flagged a transition with no enable set would miss one of these expected values. A write-one-to-clear is forced onto the exact cycle an event latches, so a design that let the clear win would lose the event. Toggling the upper 24 pins with all enables set catches a design that does not confine state to the implemented width.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int BUS_W  = 32;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFS_LEVEL = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_DIR   = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_SET   = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_CLR   = 8'h24;
    localparam logic [ADDR_W-1:0] OFS_RISE  = 8'h30;
    localparam logic [ADDR_W-1:0] OFS_FALL  = 8'h3C;
    localparam logic [ADDR_W-1:0] OFS_STAT  = 8'h48;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_LEVEL,
        SEL_DIR,
        SEL_SET,
        SEL_CLR,
        SEL_RISE,
        SEL_FALL,
        SEL_STAT
    } reg_sel_e;

    function automatic reg_sel_e decode_sel(input logic [ADDR_W-1:0] addr);
        reg_sel_e sel;
        case (addr)
            OFS_LEVEL: sel = SEL_LEVEL;
            OFS_DIR:   sel = SEL_DIR;
            OFS_SET:   sel = SEL_SET;
            OFS_CLR:   sel = SEL_CLR;
            OFS_RISE:  sel = SEL_RISE;
            OFS_FALL:  sel = SEL_FALL;
            OFS_STAT:  sel = SEL_STAT;
            default:   sel = SEL_NONE;
        endcase
        return sel;
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] level_o,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);

    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pin_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    always_comb begin
        level_o = sync_q;
        rise_o  = sync_q & ~prev_q;
        fall_o  = ~sync_q & prev_q;
    end

endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
    import gpio_bank_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  reg_sel_e     sel_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] latch_o,
    output logic [W-1:0] dir_o,
    output logic [W-1:0] rise_en_o,
    output logic [W-1:0] fall_en_o
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_o   <= '0;
            dir_o     <= '0;
            rise_en_o <= '0;
            fall_en_o <= '0;
        end else if (wr_i) begin
            unique case (sel_i)
                SEL_SET:  latch_o   <= latch_o | wdata_i;
                SEL_CLR:  latch_o   <= latch_o & ~wdata_i;
                SEL_DIR:  dir_o     <= wdata_i;
                SEL_RISE: rise_en_o <= wdata_i;
                SEL_FALL: fall_en_o <= wdata_i;
                default:  ;
            endcase
        end
    end

    AST_SET_DRIVES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && sel_i == SEL_SET) |=> ((latch_o & $past(wdata_i)) == $past(wdata_i))); // R2

    AST_CLR_DRIVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && sel_i == SEL_CLR) |=> ((latch_o & $past(wdata_i)) == '0)); // R3

    AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_i && (sel_i == SEL_SET || sel_i == SEL_CLR)) |=> $stable(latch_o)); // R4

endmodule

// File: rtl/gpio_edge_status.sv
module gpio_edge_status #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] rise_i,
    input  logic [W-1:0] fall_i,
    input  logic [W-1:0] rise_en_i,
    input  logic [W-1:0] fall_en_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] status_o,
    output logic         irq_o
);

    logic [W-1:0] events;
    logic [W-1:0] status_q;

    always_comb begin
        events = (rise_i & rise_en_i) | (fall_i & fall_en_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
        end else begin
            status_q <= (status_q & ~clr_i) | events;
        end
    end

    always_comb begin
        status_o = status_q;
        irq_o    = |status_q;
    end

    AST_EVENT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (events != '0) |=> ((status_q & $past(events)) == $past(events))); // R10

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & ~$past(status_q) & ~$past(events)) == '0)); // R8

    AST_STICKY_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_q & ~clr_i) != '0) |=>
            ((status_q & $past(status_q & ~clr_i)) == $past(status_q & ~clr_i))); // R9

endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [BUS_W-1:0]  pad_in,
    output logic [BUS_W-1:0]  pad_out,
    output logic [BUS_W-1:0]  pad_oe,
    output logic              irq
);

    localparam int W = NUM_PINS;

    reg_sel_e     sel;
    logic         wr;
    logic [W-1:0] wdata_w;
    logic [W-1:0] level;
    logic [W-1:0] rise_ev;
    logic [W-1:0] fall_ev;
    logic [W-1:0] latch;
    logic [W-1:0] dir;
    logic [W-1:0] rise_en;
    logic [W-1:0] fall_en;
    logic [W-1:0] stat_clr;
    logic [W-1:0] status;
    logic [W-1:0] rd_w;

    generate
        if (W < BUS_W) begin : g_narrow
            logic unused_hi;
            assign unused_hi = ^{pad_in[BUS_W-1:W], bus_wdata[BUS_W-1:W]};
        end
    endgenerate

    always_comb begin
        sel      = decode_sel(bus_addr);
        wr       = bus_en && bus_we;
        wdata_w  = bus_wdata[W-1:0];
        stat_clr = (wr && sel == SEL_STAT) ? wdata_w : '0;
    end

    gpio_in_sync #(.W(W)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_i   (pad_in[W-1:0]),
        .level_o (level),
        .rise_o  (rise_ev),
        .fall_o  (fall_ev)
    );

    gpio_cfg_regs #(.W(W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (wr),
        .sel_i     (sel),
        .wdata_i   (wdata_w),
        .latch_o   (latch),
        .dir_o     (dir),
        .rise_en_o (rise_en),
        .fall_en_o (fall_en)
    );

    gpio_edge_status #(.W(W)) u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise_i    (rise_ev),
        .fall_i    (fall_ev),
        .rise_en_i (rise_en),
        .fall_en_i (fall_en),
        .clr_i     (stat_clr),
        .status_o  (status),
        .irq_o     (irq)
    );

    always_comb begin
        rd_w = '0;
        unique case (sel)
            SEL_LEVEL: rd_w = level;
            SEL_DIR:   rd_w = dir;
            SEL_RISE:  rd_w = rise_en;
            SEL_FALL:  rd_w = fall_en;
            SEL_STAT:  rd_w = status;
            default:   rd_w = '0;
        endcase
        bus_rdata = bus_en ? BUS_W'(rd_w) : '0;
        pad_out   = BUS_W'(latch);
        pad_oe    = BUS_W'(dir);
    end

    AST_IRQ_FOLLOWS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel == SEL_STAT && bus_wdata == '1 && rise_ev == '0 && fall_ev == '0)
            |=> !irq); // R11

endmodule

// File: tb/test_gpio_edge_bank.sv
module test_gpio_edge_bank;

    localparam int CLK_PERIOD = 10;
    localparam int NP = 8;
    localparam logic [7:0] A_LVL = 8'h00, A_DIR = 8'h0C, A_SET = 8'h18,
        A_CLR = 8'h24, A_RISE = 8'h30, A_FALL = 8'h3C, A_STAT = 8'h48, A_AF = 8'h54;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out;
    logic [31:0] pad_oe;
    logic        irq;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_edge_bank #(.NUM_PINS(NP)) i_gpio_edge_bank (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_en = 1'b0;
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [31:0] d;
        logic [7:0]  exp_out;
        logic [7:0]  c;
        logic [31:0] bit_m;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(A_LVL, d);  chk("R1 level", d, 0);
        rd(A_DIR, d);  chk("R1 dir", d, 0);
        rd(A_RISE, d); chk("R1 rise", d, 0);
        rd(A_FALL, d); chk("R1 fall", d, 0);
        rd(A_STAT, d); chk("R1 stat", d, 0);
        chk("R1 pad_out", pad_out, 0);
        chk("R1 pad_oe", pad_oe, 0);
        chk("R1 irq", {31'b0, irq}, 0);

        // R2 R3 sweep of set and clear patterns
        exp_out = '0;
        for (int v = 0; v < 256; v++) begin
            wr(A_SET, 32'(v));
            exp_out = exp_out | 8'(v);
            chk("R2 set", pad_out, {24'b0, exp_out});
            c = 8'((v * 29 + 7) & 8'hFF);
            wr(A_CLR, {24'b0, c});
            exp_out = exp_out & ~c;
            chk("R3 clear", pad_out, {24'b0, exp_out});
        end
        rd(A_SET, d); chk("R2 set reads zero", d, 0);
        rd(A_CLR, d); chk("R3 clear reads zero", d, 0);

        // R4 direction sweep; latch untouched
        wr(A_SET, 32'h5A);
        wr(A_CLR, 32'hA5);
        for (int v = 0; v < 256; v++) begin
            wr(A_DIR, 32'(v));
            chk("R4 pad_oe", pad_oe, 32'(v));
            rd(A_DIR, d); chk("R4 dir read", d, 32'(v));
            chk("R4 latch kept", pad_out, 32'h5A);
        end

        // R13 unmapped offset
        wr(A_AF, 32'hFFFF_FFFF);
        rd(A_AF, d); chk("R13 unmapped read", d, 0);
        chk("R13 pad_out unchanged", pad_out, 32'h5A);
        chk("R13 pad_oe unchanged", pad_oe, 32'hFF);
        rd(A_RISE, d); chk("R13 rise unchanged", d, 0);

        // R5 level timing
        pad_in = 32'h0000_00A5;
        @(negedge clk);
        rd(A_LVL, d); chk("R5 level not after one edge", d, 0);
        @(negedge clk);
        rd(A_LVL, d); chk("R5 level after two edges", d, 32'hA5);
        pad_in = '0;
        repeat (3) @(negedge clk);
        rd(A_STAT, d); chk("R8 no enables no status", d, 0);

        // R6 R7 R8 R9 R11 per pin, all enable combinations
        for (int p = 0; p < NP; p++) begin
            for (int m = 0; m < 4; m++) begin
                bit_m = 32'h1 << p;
                wr(A_RISE, m[0] ? bit_m : 32'h0);
                wr(A_FALL, m[1] ? bit_m : 32'h0);
                pad_in[p] = 1'b1;
                repeat (2) @(negedge clk);
                rd(A_STAT, d); chk("R6 not early", d, 0);
                @(negedge clk);
                rd(A_STAT, d); chk("R6 R8 rising", d, m[0] ? bit_m : 32'h0);
                chk("R11 irq rise", {31'b0, irq}, {31'b0, m[0]});
                wr(A_STAT, bit_m);
                rd(A_STAT, d); chk("R9 cleared", d, 0);
                pad_in[p] = 1'b0;
                repeat (3) @(negedge clk);
                rd(A_STAT, d); chk("R7 R8 falling", d, m[1] ? bit_m : 32'h0);
                chk("R11 irq fall", {31'b0, irq}, {31'b0, m[1]});
                wr(A_STAT, 32'hFFFF_FFFF);
                chk("R11 irq low after clear", {31'b0, irq}, 0);
            end
        end

        // R9 partial clear keeps other bits
        wr(A_RISE, 32'h03);
        wr(A_FALL, 32'h00);
        pad_in = 32'h03;
        repeat (3) @(negedge clk);
        rd(A_STAT, d); chk("R9 two set", d, 32'h03);
        wr(A_STAT, 32'h01);
        rd(A_STAT, d); chk("R9 partial clear", d, 32'h02);
        chk("R11 irq one bit", {31'b0, irq}, 1);
        wr(A_STAT, 32'hFFFF_FFFF);
        rd(A_STAT, d); chk("R9 clear all", d, 0);
        pad_in = '0;
        repeat (3) @(negedge clk);

        // R10 event coincides with clear
        wr(A_RISE, 32'h08);
        wr(A_FALL, 32'h08);
        pad_in[3] = 1'b1;
        repeat (3) @(negedge clk);
        rd(A_STAT, d); chk("R10 setup", d, 32'h08);
        pad_in[3] = 1'b0;
        repeat (2) @(negedge clk);
        wr(A_STAT, 32'h08);
        rd(A_STAT, d); chk("R10 event wins over clear", d, 32'h08);
        wr(A_STAT, 32'h08);
        rd(A_STAT, d); chk("R10 plain clear", d, 0);

        // R12 unimplemented upper pins
        wr(A_RISE, 32'hFFFF_FFFF);
        wr(A_FALL, 32'hFFFF_FFFF);
        rd(A_RISE, d); chk("R12 rise width", d, 32'hFF);
        rd(A_FALL, d); chk("R12 fall width", d, 32'hFF);
        pad_in = 32'hFFFF_FF00;
        repeat (3) @(negedge clk);
        rd(A_STAT, d); chk("R12 no upper status", d, 0);
        rd(A_LVL, d); chk("R12 upper level zero", d, 0);
        chk("R12 irq quiet", {31'b0, irq}, 0);
        pad_in = '0;
        repeat (3) @(negedge clk);
        wr(A_SET, 32'hFFFF_FFFF);
        chk("R12 pad_out width", pad_out, 32'hFF);
        wr(A_DIR, 32'hFFFF_FFFF);
        chk("R12 pad_oe width", pad_oe, 32'hFF);
        rd(A_DIR, d); chk("R12 dir width", d, 32'hFF);

        summary();
    end

endmodule